// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block turns a digital "supply below threshold" indication from an external comparator into a clean device reset. A qualified supply dip (one that lasts a programmable number of clock cycles) puts the device into brown-out reset. The reset holds for as long as the supply stays low. After recovery, an optional power-up hold-off timer keeps the device in reset for a fixed number of further cycles. If the supply dips again while that timer runs, the block drops straight back into brown-out reset and the timer starts over.

A 2-bit configuration selects one of four detection modes: off, gated by a software enable bit, hardware-controlled but suspended during sleep, and always on. The block also keeps a brown-out status flag. Every brown-out entry and every power-on reset force the flag to 0. Software sets it back to 1 with a strobe, which lets software tell a brown-out apart from other resets.

Top module: `bor_sequencer`

## Requirements
- R1: With `enCfg` = 2'b00, supply-low indications never cause a reset.
- R2: With `enCfg` = 2'b01, detection is on only while `swEnable` is 1. `swEnableRd` equals `swEnable` in this mode and reads 0 in every other mode.
- R3: With `enCfg` = 2'b10, detection is off while `sleepMode` is 1 and comes back on by itself when `sleepMode` returns to 0.
- R4: With `enCfg` = 2'b11, detection is on whatever the value of `sleepMode`.
- R5: While detection is on and no reset is active, `borReset` rises at the clock edge that samples `supplyLow` high for the FILT_CYCLES-th consecutive time. A pulse sampled for fewer edges causes no reset, and the count starts again from zero.
- R6: `borReset` stays 1 for as long as `supplyLow` is 1, and it falls at the first edge that samples `supplyLow` low.
- R7: When `borReset` falls and `pwrtEnable` is 1, `pwrtActive` is 1 for exactly PWRT_CYCLES cycles. When `pwrtEnable` is 0, reset ends at once. `devReset` is 1 whenever `borReset` or `pwrtActive` is 1. The timer enable has no link to the detection mode.
- R8: A `supplyLow` sample, with detection on, during the hold-off period returns the block to `borReset` at the next edge with no filtering. The full PWRT_CYCLES delay then restarts after recovery.
- R9: `borFlag` is 0 after `porIn` and is cleared at every entry into brown-out reset. A one-cycle `flagSet` strobe sets it to 1. If a clear and a set fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porIn | input | 1 | Power-on reset, active high, asynchronous |
| supplyLow | input | 1 | Comparator output, 1 = supply below threshold |
| enCfg | input | 2 | Detection mode: 00 off, 01 software, 10 off in sleep, 11 on |
| swEnable | input | 1 | Software detection enable, used in mode 01 |
| sleepMode | input | 1 | Device is in sleep |
| pwrtEnable | input | 1 | Enables the power-up hold-off timer |
| flagSet | input | 1 | Software strobe that sets the status flag |
| borReset | output | 1 | Brown-out reset active |
| pwrtActive | output | 1 | Hold-off timer running |
| devReset | output | 1 | Combined reset to the device |
| borFlag | output | 1 | Brown-out status flag (0 = brown-out seen) |
| swEnableRd | output | 1 | Read value of the software enable bit |

## Verification
Two functions can fall in the same cycle. Brown-out entry clears the status flag, while software can set it with `flagSet`. The bench holds `flagSet` high exactly in the cycle in which the filter count completes, and again on the dip that interrupts the hold-off timer. In both cases it expects `borReset` at 1 and `borFlag` at 0 after the edge. A following lone strobe must then read back as 1.

// File: rtl/bor_seq_pkg.sv
package bor_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BOR  = 2'd1,
    ST_PWRT = 2'd2
  } borState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic lowCount;   // qualified low sample in run state
    logic pwrtRun;    // hold-off timer advances
    logic flagClear;  // brown-out entry this cycle
  } borStrobe_t;

  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_SOFT  = 2'b01;
  localparam logic [1:0] MODE_SLEEP = 2'b10;
  localparam logic [1:0] MODE_ON    = 2'b11;

endpackage

// File: rtl/bor_seq_ctrl.sv
module bor_seq_ctrl
  import bor_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porIn,
  input  logic       supplyLow,
  input  logic [1:0] enCfg,
  input  logic       swEnable,
  input  logic       sleepMode,
  input  logic       pwrtEnable,
  input  logic       lowDone,
  input  logic       pwrtDone,
  output borStrobe_t strobe,
  output borState_e  state,
  output logic       detectOn,
  output logic       swEnableRd
);

  borState_e stNext;
  logic      dipSeen;

  always_comb begin
    unique case (enCfg)
      MODE_OFF:   detectOn = 1'b0;
      MODE_SOFT:  detectOn = swEnable;
      MODE_SLEEP: detectOn = !sleepMode;
      default:    detectOn = 1'b1;
    endcase
  end

  assign swEnableRd = (enCfg == MODE_SOFT) && swEnable;
  assign dipSeen    = supplyLow && detectOn;

  always_comb begin
    stNext = state;
    unique case (state)
      ST_RUN:  if (lowDone) stNext = ST_BOR;
      ST_BOR:  if (!supplyLow) stNext = pwrtEnable ? ST_PWRT : ST_RUN;
      ST_PWRT: begin
        if (dipSeen)       stNext = ST_BOR;
        else if (pwrtDone) stNext = ST_RUN;
      end
      default: stNext = ST_RUN;
    endcase
  end

  always_comb begin
    strobe.lowCount  = (state == ST_RUN) && dipSeen;
    strobe.pwrtRun   = (state == ST_PWRT) && !dipSeen;
    strobe.flagClear = ((state == ST_RUN) && lowDone) ||
                       ((state == ST_PWRT) && dipSeen);
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) state <= ST_RUN;
    else       state <= stNext;
  end

  // R1: mode off never enters brown-out from run
  a_r1_off_no_trip: assert property (@(posedge clk) disable iff (porIn)
    (enCfg == MODE_OFF && state == ST_RUN) |=> state != ST_BOR);

  // R6: reset held while supply still low
  a_r6_hold_low: assert property (@(posedge clk) disable iff (porIn)
    (state == ST_BOR && supplyLow) |=> state == ST_BOR);

  // R8: dip during hold-off returns to brown-out at once
  a_r8_dip_restart: assert property (@(posedge clk) disable iff (porIn)
    (state == ST_PWRT && supplyLow && detectOn) |=> state == ST_BOR);

  // R7: without the timer, recovery goes straight to run
  a_r7_no_timer: assert property (@(posedge clk) disable iff (porIn)
    (state == ST_BOR && !supplyLow && !pwrtEnable) |=> state == ST_RUN);

endmodule

// File: rtl/bor_seq_datapath.sv
module bor_seq_datapath
  import bor_seq_pkg::*;
#(
  parameter int FILT_CYCLES = 4,
  parameter int PWRT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porIn,
  input  borStrobe_t strobe,
  input  logic       flagSet,
  output logic       lowDone,
  output logic       pwrtDone,
  output logic       borFlag
);

  localparam int LW = $clog2(FILT_CYCLES + 1);
  localparam int PW = $clog2(PWRT_CYCLES + 1);
  localparam logic [LW-1:0] LOW_LAST  = LW'(FILT_CYCLES - 1);
  localparam logic [PW-1:0] PWRT_LAST = PW'(PWRT_CYCLES - 1);

  logic [LW-1:0] lowCnt;
  logic [PW-1:0] pwrtCnt;

  assign lowDone  = strobe.lowCount && (lowCnt == LOW_LAST);
  assign pwrtDone = strobe.pwrtRun && (pwrtCnt == PWRT_LAST);

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      lowCnt  <= '0;
      pwrtCnt <= '0;
      borFlag <= 1'b0;
    end else begin
      lowCnt  <= (strobe.lowCount && !lowDone) ? lowCnt + 1'b1 : '0;
      pwrtCnt <= (strobe.pwrtRun && !pwrtDone) ? pwrtCnt + 1'b1 : '0;
      if (strobe.flagClear) borFlag <= 1'b0;
      else if (flagSet)     borFlag <= 1'b1;
    end
  end

  // R9: brown-out entry leaves the flag cleared
  a_r9_flag_cleared: assert property (@(posedge clk) disable iff (porIn)
    strobe.flagClear |=> !borFlag);

  // R5: filter count stays below its limit
  a_r5_filter_bound: assert property (@(posedge clk) disable iff (porIn)
    lowCnt < LW'(FILT_CYCLES));

  // R7: hold-off count stays below its limit
  a_r7_pwrt_bound: assert property (@(posedge clk) disable iff (porIn)
    pwrtCnt < PW'(PWRT_CYCLES));

endmodule

// File: rtl/bor_sequencer.sv
module bor_sequencer
  import bor_seq_pkg::*;
#(
  parameter int FILT_CYCLES = 4,
  parameter int PWRT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porIn,
  input  logic       supplyLow,
  input  logic [1:0] enCfg,
  input  logic       swEnable,
  input  logic       sleepMode,
  input  logic       pwrtEnable,
  input  logic       flagSet,
  output logic       borReset,
  output logic       pwrtActive,
  output logic       devReset,
  output logic       borFlag,
  output logic       swEnableRd
);

  borStrobe_t strobe;
  borState_e  state;
  logic       lowDone, pwrtDone, detectOn;

  bor_seq_ctrl u_ctrl (
    .clk(clk), .porIn(porIn), .supplyLow(supplyLow), .enCfg(enCfg),
    .swEnable(swEnable), .sleepMode(sleepMode), .pwrtEnable(pwrtEnable),
    .lowDone(lowDone), .pwrtDone(pwrtDone), .strobe(strobe),
    .state(state), .detectOn(detectOn), .swEnableRd(swEnableRd)
  );

  bor_seq_datapath #(.FILT_CYCLES(FILT_CYCLES), .PWRT_CYCLES(PWRT_CYCLES)) u_dp (
    .clk(clk), .porIn(porIn), .strobe(strobe), .flagSet(flagSet),
    .lowDone(lowDone), .pwrtDone(pwrtDone), .borFlag(borFlag)
  );

  assign borReset   = (state == ST_BOR);
  assign pwrtActive = (state == ST_PWRT);
  assign devReset   = borReset || pwrtActive;

  // R3: sleep suspends detection in mode 10
  a_r3_sleep_off: assert property (@(posedge clk) disable iff (porIn)
    (enCfg == MODE_SLEEP && sleepMode) |-> !detectOn);

  // R2: readback is zero outside mode 01
  a_r2_readback: assert property (@(posedge clk) disable iff (porIn)
    (enCfg != MODE_SOFT) |-> !swEnableRd);

endmodule

// File: tb/bor_sequencer_test.sv
module bor_sequencer_test;

  localparam int FILT = 4;
  localparam int PWRT = 16;

  logic clk = 1'b0;
  logic porIn = 1'b1;
  logic supplyLow = 1'b0;
  logic [1:0] enCfg = 2'b11;
  logic swEnable = 1'b0, sleepMode = 1'b0, pwrtEnable = 1'b0, flagSet = 1'b0;
  logic borReset, pwrtActive, devReset, borFlag, swEnableRd;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bor_sequencer #(.FILT_CYCLES(FILT), .PWRT_CYCLES(PWRT)) uut (
    .clk(clk), .porIn(porIn), .supplyLow(supplyLow), .enCfg(enCfg),
    .swEnable(swEnable), .sleepMode(sleepMode), .pwrtEnable(pwrtEnable),
    .flagSet(flagSet), .borReset(borReset), .pwrtActive(pwrtActive),
    .devReset(devReset), .borFlag(borFlag), .swEnableRd(swEnableRd)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic doPor();
    porIn = 1'b1; step(2); porIn = 1'b0; step(1);
  endtask

  task automatic tResetState();
    doPor();
    chk("R7 devReset after por", devReset, 1'b0);
    chk("R6 borReset after por", borReset, 1'b0);
    chk("R9 borFlag after por", borFlag, 1'b0);
  endtask

  task automatic tFilter();
    enCfg = 2'b11; sleepMode = 1'b1; pwrtEnable = 1'b0;   // R4 in sleep
    supplyLow = 1'b1; step(FILT - 1); supplyLow = 1'b0; step(1);
    chk("R5 short pulse", borReset, 1'b0);
    supplyLow = 1'b1; step(FILT - 1);
    chk("R5 one edge early", borReset, 1'b0);
    step(1);
    chk("R4 R5 trip in sleep", borReset, 1'b1);
    step(10);
    chk("R6 held while low", borReset, 1'b1);
    supplyLow = 1'b0; step(1);
    chk("R7 no timer release", devReset, 1'b0);
    sleepMode = 1'b0;
  endtask

  task automatic tModeOff();
    enCfg = 2'b00; supplyLow = 1'b1; step(20);
    chk("R1 mode off", devReset, 1'b0);
    supplyLow = 1'b0; step(1);
  endtask

  task automatic tModeSoft();
    enCfg = 2'b01; swEnable = 1'b0; supplyLow = 1'b1; step(10);
    chk("R2 soft disabled", borReset, 1'b0);
    chk("R2 readback off", swEnableRd, 1'b0);
    swEnable = 1'b1; step(FILT);
    chk("R2 soft enabled trip", borReset, 1'b1);
    chk("R2 readback on", swEnableRd, 1'b1);
    supplyLow = 1'b0; step(1);
    enCfg = 2'b11; step(1);
    chk("R2 readback other mode", swEnableRd, 1'b0);
    swEnable = 1'b0;
  endtask

  task automatic tModeSleep();
    enCfg = 2'b10; sleepMode = 1'b1; supplyLow = 1'b1; step(10);
    chk("R3 off in sleep", borReset, 1'b0);
    sleepMode = 1'b0; step(FILT);
    chk("R3 on after wake", borReset, 1'b1);
    supplyLow = 1'b0; step(1);
    enCfg = 2'b11;
  endtask

  task automatic tPwrt();
    pwrtEnable = 1'b1; supplyLow = 1'b1; step(FILT);
    chk("R5 trip before timer", borReset, 1'b1);
    supplyLow = 1'b0; step(1);
    chk("R7 timer starts", pwrtActive, 1'b1);
    chk("R7 devReset during timer", devReset, 1'b1);
    step(PWRT - 1);
    chk("R7 last timer cycle", devReset, 1'b1);
    step(1);
    chk("R7 timer release", devReset, 1'b0);
  endtask

  task automatic tPwrtDip();
    pwrtEnable = 1'b1; supplyLow = 1'b1; step(FILT);
    supplyLow = 1'b0; step(1);
    step(3);
    flagSet = 1'b1; step(1); flagSet = 1'b0;
    chk("R9 set during timer", borFlag, 1'b1);
    supplyLow = 1'b1; flagSet = 1'b1; step(1); flagSet = 1'b0;
    chk("R8 dip re-enters reset", borReset, 1'b1);
    chk("R9 dip clear beats set", borFlag, 1'b0);
    supplyLow = 1'b0; step(1);
    chk("R8 timer restarted", pwrtActive, 1'b1);
    step(PWRT - 1);
    chk("R8 full delay again", devReset, 1'b1);
    step(1);
    chk("R8 release after restart", devReset, 1'b0);
    pwrtEnable = 1'b0;
  endtask

  task automatic tFlag();
    flagSet = 1'b1; step(1); flagSet = 1'b0;
    chk("R9 software set", borFlag, 1'b1);
    supplyLow = 1'b1; step(FILT - 1);
    flagSet = 1'b1; step(1); flagSet = 1'b0;
    chk("R9 trip same cycle reset", borReset, 1'b1);
    chk("R9 trip same cycle flag", borFlag, 1'b0);
    supplyLow = 1'b0; step(1);
    flagSet = 1'b1; step(1); flagSet = 1'b0;
    chk("R9 set after brown-out", borFlag, 1'b1);
    doPor();
    chk("R9 por clears flag", borFlag, 1'b0);
  endtask

  initial begin
    tResetState();
    tFilter();
    tModeOff();
    tModeSoft();
    tModeSleep();
    tPwrt();
    tPwrtDip();
    tFlag();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule